// File: doc/BRIEF.md
# Startup Memory Configuration Bit Responder

At power-up a processor reads its external memory timing settings one bit at a time. It puts a word address on a shared address/data bus and pulls the address strobe low. For each address, this block answers with one bit. The bit comes from a stored pattern indexed by six word-address bits. The pattern encodes 13 timing fields: half-cycle counts for each bus state and each user strobe, plus the refresh options. Because the bus carries data after the address, the answer is captured when the strobe falls. It then holds steady until the next strobe fall.

Before the real reads begin, the processor runs a scan. The bus starts with every line high. The lines then go low one by one, from bit 0 upward, and each stays low. Throughout this scan the block must keep answering "respond". While the top address bit is still high, that bit alone keeps the answer on. Once the top bit drops, the all-zero index keeps it on. The pin toward the processor is active low, so "respond" drives it to 0.

Top module: `cfg_bit_responder`

## Requirements
- R1: After reset and before any strobe fall, `cfg_pin_n` is 1.
- R2: On a strobe fall with `bus_ad[31]` = 0 and a nonzero index `bus_ad[7:2]`, `cfg_pin_n` becomes the inverse of bit `bus_ad[7:2]` of the `PATTERN` parameter. The default `PATTERN` is 64'hB4E1_3A96_5C0F_72D8.
- R3: Bus bits 1:0 and 30:8 have no effect on the captured answer.
- R4: On a strobe fall with `bus_ad[31]` = 1, `cfg_pin_n` becomes 0 whatever the other bits are.
- R5: On a strobe fall with `bus_ad[7:2]` = 0, `cfg_pin_n` becomes 0.
- R6: The answer is captured at the first clock edge that sees `strobe_n` low after it was high. Bus changes while the strobe stays low leave `cfg_pin_n` unchanged.
- R7: A rising or high strobe never changes `cfg_pin_n`, so the last answer holds between cycles.
- R8: Through a full walking-zero scan (all lines high, then bit 0 through bit 31 cleared one at a time with one strobe cycle per step), `cfg_pin_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 32 | Multiplexed address/data bus |
| strobe_n | input | 1 | Active-low address strobe; its fall marks a valid address |
| cfg_pin_n | output | 1 | Active-low configuration bit to the processor |

## Verification
The hardest situation to reach is the hand-over inside the scan. This is the step where bit 31 drops and the index bits are already zero, so the answer switches from the top-bit term to the zero-index term with no cycle of 0 between them. The bench reaches it by walking the whole scan one strobe cycle per step. It also checks captures that hold while the bus keeps changing under a low strobe.

// File: rtl/cfg_resp_pkg.sv
package cfg_resp_pkg;

    // register state of the strobe edge detector
    typedef struct packed {
        logic strb_prev;
    } edge_st_t;

    // register state of the answer latch
    typedef struct packed {
        logic resp;
    } latch_st_t;

endpackage

// File: rtl/cfg_strobe_edge.sv
module cfg_strobe_edge
    import cfg_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic strb_q,
    output logic fall
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.strb_prev = strobe_n;
        fall           = st_q.strb_prev & ~strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{strb_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign strb_q = st_q.strb_prev;
endmodule

// File: rtl/cfg_pattern_lookup.sv
module cfg_pattern_lookup #(
    parameter int unsigned IDX_W = 6,
    parameter logic [(1<<IDX_W)-1:0] PATTERN = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] sel_vec;

    // one decoded term per entry whose pattern bit is set
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        if (PATTERN[i]) begin : g_set
            assign sel_vec[i] = (idx == IDX_W'(i));
        end else begin : g_clr
            assign sel_vec[i] = 1'b0;
        end
    end

    assign hit = |sel_vec;
endmodule

// File: rtl/cfg_scan_guard.sv
module cfg_scan_guard #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             msb,
    input  logic [IDX_W-1:0] idx,
    output logic             keep
);
    // top line high: early part of scan; index all low: late part of scan
    always_comb keep = msb | (idx == '0);
endmodule

// File: rtl/cfg_bit_responder.sv
module cfg_bit_responder
    import cfg_resp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_LO = 2,
    parameter int unsigned IDX_W  = 6,
    parameter logic [(1<<IDX_W)-1:0] PATTERN = 64'hB4E1_3A96_5C0F_72D8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_ad,
    input  logic              strobe_n,
    output logic              cfg_pin_n
);
    localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0] idx;
    logic             msb, hit, keep, fall, strb_q, respond;
    logic             unused_bits;
    latch_st_t        st_d, st_q;

    assign idx         = bus_ad[IDX_HI:IDX_LO];
    assign msb         = bus_ad[ADDR_W-1];
    assign unused_bits = ^{bus_ad[IDX_LO-1:0], bus_ad[ADDR_W-2:IDX_HI+1]};

    cfg_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .strb_q   (strb_q),
        .fall     (fall)
    );

    cfg_pattern_lookup #(.IDX_W(IDX_W), .PATTERN(PATTERN)) u_lookup (
        .idx (idx),
        .hit (hit)
    );

    cfg_scan_guard #(.IDX_W(IDX_W)) u_guard (
        .msb  (msb),
        .idx  (idx),
        .keep (keep)
    );

    always_comb begin
        st_d    = st_q;
        respond = keep | hit;
        if (fall) st_d.resp = respond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{resp: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_pin_n = ~st_q.resp;

    // R1: pin inactive at the first edge after reset release
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_pin_n);

    // R2: non-scan capture follows the looked-up pattern bit
    assert_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_q && !strobe_n && !msb && idx != '0) |=> (cfg_pin_n == !$past(hit)));

    // R4: top line high forces respond
    assert_msb_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_q && !strobe_n && msb) |=> !cfg_pin_n);

    // R5: all-low index forces respond
    assert_zero_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_q && !strobe_n && idx == '0) |=> !cfg_pin_n);

    // R6: held strobe keeps the answer
    assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_q && !strobe_n) |=> $stable(cfg_pin_n));

    // R7: high strobe never updates the answer
    assert_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> $stable(cfg_pin_n));
endmodule

// File: tb/cfg_bit_responder_tb.sv
module cfg_bit_responder_tb;
    localparam logic [63:0] PAT = 64'hB4E1_3A96_5C0F_72D8;
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_0004, 32'h0000_0008, 32'h0000_00FC, 32'h8000_0020,
        32'h0000_0000, 32'h7FFF_FF03, 32'h0000_0054, 32'h0012_3498,
        32'hFFFF_FF00, 32'h0000_00A8
    };

    logic        clk = 0, rst_n = 0, strobe_n = 1;
    logic [31:0] bus_ad = '0;
    logic        cfg_pin_n;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    cfg_bit_responder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad),
        .strobe_n(strobe_n), .cfg_pin_n(cfg_pin_n)
    );

    function automatic logic exp_pin(logic [31:0] a);
        logic [5:0] i;
        i = a[7:2];
        return !(a[31] || i == 6'd0 || PAT[i]);
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    // one strobe cycle; the answer is registered at the edge after the fall
    task automatic bus_cycle(logic [31:0] a, string req, bit hold_chk);
        logic e;
        e = exp_pin(a);
        @(negedge clk); bus_ad = a; strobe_n = 0;
        @(negedge clk); check(req, cfg_pin_n, e);
        if (hold_chk) begin
            bus_ad = ~a;
            @(negedge clk); check("R6 hold under low strobe", cfg_pin_n, e);
            strobe_n = 1; bus_ad = 32'h0000_0000;
            @(negedge clk); check("R7 no update on high strobe", cfg_pin_n, e);
        end else begin
            strobe_n = 1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset idle", cfg_pin_n, 1'b1);
        rst_n = 1;
        @(negedge clk); check("R1 idle after release", cfg_pin_n, 1'b1);

        // directed vector table (R2 R3 R4 R5 R6 R7)
        for (int v = 0; v < NV; v++) bus_cycle(VEC[v], "R2 vector table", 1'b1);

        // every entry, with noisy ignored bits (R2, R3)
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = {1'b0, 23'h5A5A5A ^ 23'(i * 97), 6'(i), 2'(i)};
            bus_cycle(a, "R2 R3 pattern entry", 1'b0);
        end

        // R4 top line forces respond on an entry that is clear
        bus_cycle(32'h8000_0004, "R4 top line", 1'b0);
        // R5 zero index with other bits set
        bus_cycle(32'h7FFF_FF03, "R5 zero index", 1'b0);

        // R8 walking-zero scan
        begin
            logic [31:0] s;
            s = '1;
            bus_cycle(s, "R8 scan start", 1'b0);
            for (int b = 0; b < 32; b++) begin
                s[b] = 1'b0;
                bus_cycle(s, "R8 scan step", 1'b0);
                check("R8 scan pin low", cfg_pin_n, 1'b0);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule